// File: doc/BRIEF.md
# Cascaded Interrupt Priority Controller

This block raises and retires the interrupt of one peripheral that shares an interrupt line with other devices. It merges internal pending requests into an active-high interrupt output and watches an acknowledge strobe to decide whether the current acknowledge cycle belongs to this device. A static mode input picks the arbitration scheme. In address mode, a 3-bit code on the enable pins must equal a programmed device address. In chain mode, a priority input from the upstream device and a priority output to the downstream device pass the grant along a chain.

A second static input selects single-strobe or double-strobe acknowledge sequences. While any acknowledge sequence is in progress, no device starts a new interrupt. In double-strobe mode this hold-off lasts until the second strobe ends. The acknowledge strobe and enable pins are asynchronous. They pass through a two-stage synchronizer, and all responses are timed from the synchronized values.

Top module: `irq_cascade_ctl`

## Requirements
- R1: After reset, `int_out` and `ack_pulse` are 0, and so is `prio_out`.
- R2: In address mode (`chain_mode`=0), any set bit of `req_pend` with no acknowledge hold-off raises `int_out` one cycle later, whatever the enable pins are. `prio_oe` and `prio_out` stay 0.
- R3: In address mode, when `en_in` equals `slave_addr` at the rising edge of a first strobe of `inta`, and `int_out` is high, `ack_pulse` rises 3 cycles after `inta` rises. `int_out` falls in that same cycle.
- R4: In address mode, a strobe whose `en_in` differs from `slave_addr` gives no `ack_pulse`, and `int_out` stays high.
- R5: In chain mode, `en_in[1]` is the priority input. When it is 0, `int_out` and `prio_out` go low 2 cycles later and stay low for as long as it stays 0. `en_in[2]` has no effect in this mode.
- R6: In chain mode, `prio_out` is 0 while `int_out` is active. It is 1 only when `int_out` is low and the priority input is 1.
- R7: In chain mode, a strobe gives an accept only if the priority input is 1 at the strobe's rising edge.
- R8: With `two_ack`=0, no interrupt starts from the moment a strobe is seen until it ends. A pending request raises `int_out` 4 cycles after `inta` falls.
- R9: With `two_ack`=1, the hold-off lasts until the second strobe ends. The second strobe never gives an accept.
- R10: `ack_pulse` lasts exactly one clock per accepted sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chain_mode | input | 1 | 0: address mode, 1: chain mode |
| two_ack | input | 1 | 1: two acknowledge strobes per sequence |
| slave_addr | input | ADDR_W | Programmed device address |
| req_pend | input | SRC_W | Internal pending requests |
| en_in | input | ADDR_W | Enable pins; bit 1 is the priority input in chain mode |
| inta | input | 1 | Acknowledge strobe, active high, asynchronous |
| int_out | output | 1 | Interrupt request, active high |
| prio_out | output | 1 | Priority output to the next device |
| prio_oe | output | 1 | Drive enable for the priority output pin |
| ack_pulse | output | 1 | One-clock pulse on an accepted acknowledge |

## Verification
A change on `inta` or `en_in` takes two cycles to reach the synchronized value. An acknowledge accept and the resulting drop of the interrupt take one more cycle, which gives 3 cycles. The combinational abort by the priority input takes 2 cycles. After a strobe ends, the hold-off clears one register later, and the interrupt returns a cycle after that, 4 cycles after the fall. A change on `req_pend` alone shows on `int_out` after 1 cycle. The bench drives inputs on the falling clock edge and samples on a later falling edge after exactly that many rising edges. Where the cycle just before the due cycle matters, it also checks that cycle.

// File: rtl/irq_cascade_ctl.sv
module irq_cascade_ctl #(
  parameter int SRC_W  = 4,
  parameter int ADDR_W = 3,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chain_mode,
  input  logic              two_ack,
  input  logic [ADDR_W-1:0] slave_addr,
  input  logic [SRC_W-1:0]  req_pend,
  input  logic [ADDR_W-1:0] en_in,
  input  logic              inta,
  output logic              int_out,
  output logic              prio_out,
  output logic              prio_oe,
  output logic              ack_pulse
);

  localparam int SW = ADDR_W + 1;

  logic [SYNC_N-1:0][SW-1:0] sync;
  logic [ADDR_W-1:0] en_s;
  logic inta_s, inta_q, busy, second, int_q, ack_q;
  logic pend, prio_in, gate, inta_rise, inta_fall, suppress, match, accept;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= '0;
    else begin
      sync[0] <= {inta, en_in};
      for (int i = 1; i < SYNC_N; i++) sync[i] <= sync[i-1];
    end

  assign inta_s    = sync[SYNC_N-1][ADDR_W];
  assign en_s      = sync[SYNC_N-1][ADDR_W-1:0];
  assign pend      = |req_pend;
  assign prio_in   = en_s[1];
  assign gate      = ~chain_mode | prio_in;
  assign inta_rise = inta_s & ~inta_q;
  assign inta_fall = ~inta_s & inta_q;
  assign suppress  = inta_s | busy;
  assign match     = chain_mode ? prio_in : (en_s == slave_addr);
  assign accept    = inta_rise & ~second & int_q & match;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      inta_q <= 1'b0;
      busy   <= 1'b0;
      second <= 1'b0;
      int_q  <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      inta_q <= inta_s;
      ack_q  <= accept;
      if (inta_rise) busy <= 1'b1;
      else if (inta_fall && (!two_ack || second)) busy <= 1'b0;
      if (inta_fall) second <= two_ack & ~second;
      if (accept || !gate || !pend) int_q <= 1'b0;
      else if (!suppress) int_q <= 1'b1;
    end

  assign int_out   = int_q & gate;
  assign prio_out  = chain_mode & prio_in & ~int_q;
  assign prio_oe   = chain_mode;
  assign ack_pulse = ack_q;

  p_ack_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);

  p_ack_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> !int_q);

  p_addr_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && !chain_mode) |-> $past(en_s == slave_addr));

  p_chain_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_mode && !prio_in) |=> !int_q);

  p_prio_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int_q |-> !prio_out);

  p_no_trigger_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_q) |-> $past(!inta_s && !busy));

  p_chain_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && chain_mode) |-> $past(prio_in));

endmodule

// File: tb/sim_irq_cascade_ctl.sv
module sim_irq_cascade_ctl;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic chain_mode = 1'b0, two_ack = 1'b0, inta = 1'b0;
  logic [2:0] slave_addr = '0, en_in = '0;
  logic [3:0] req_pend = '0;
  logic int_out, prio_out, prio_oe, ack_pulse;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_cascade_ctl u0 (
    .clk(clk), .rst_n(rst_n), .chain_mode(chain_mode), .two_ack(two_ack),
    .slave_addr(slave_addr), .req_pend(req_pend), .en_in(en_in), .inta(inta),
    .int_out(int_out), .prio_out(prio_out), .prio_oe(prio_oe), .ack_pulse(ack_pulse)
  );

  // {chain, en[2:0], addr[2:0], req[3:0], 3'b0, exp_int, exp_prio}
  localparam logic [15:0] VEC [9] = '{
    {1'b0, 3'b000, 3'b000, 4'b0000, 3'b0, 1'b0, 1'b0},
    {1'b0, 3'b101, 3'b010, 4'b0100, 3'b0, 1'b1, 1'b0},
    {1'b0, 3'b000, 3'b000, 4'b1000, 3'b0, 1'b1, 1'b0},
    {1'b1, 3'b010, 3'b000, 4'b0000, 3'b0, 1'b0, 1'b1},
    {1'b1, 3'b010, 3'b000, 4'b0001, 3'b0, 1'b1, 1'b0},
    {1'b1, 3'b000, 3'b000, 4'b0001, 3'b0, 1'b0, 1'b0},
    {1'b1, 3'b110, 3'b000, 4'b0010, 3'b0, 1'b1, 1'b0},
    {1'b1, 3'b111, 3'b000, 4'b0000, 3'b0, 1'b0, 1'b1},
    {1'b1, 3'b101, 3'b000, 4'b0000, 3'b0, 1'b0, 1'b0}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    chk("R1", "int_out", int_out, 1'b0);
    chk("R1", "ack_pulse", ack_pulse, 1'b0);
    chk("R1", "prio_out", prio_out, 1'b0);
    rst_n = 1'b1;
    step(2);

    // table walk: R2, R5, R6
    for (int i = 0; i < 9; i++) begin
      {chain_mode, en_in, slave_addr, req_pend} = VEC[i][15:5];
      step(4);
      chk(VEC[i][15] ? "R5" : "R2", $sformatf("vec%0d int_out", i), int_out, VEC[i][1]);
      chk(VEC[i][15] ? "R6" : "R2", $sformatf("vec%0d prio_out", i), prio_out, VEC[i][0]);
      chk("R2", $sformatf("vec%0d prio_oe", i), prio_oe, VEC[i][15]);
    end

    // R2 one-cycle latency on request
    chain_mode = 0; two_ack = 0; req_pend = 0; step(3);
    req_pend = 4'b0010; step(1);
    chk("R2", "int one cycle after request", int_out, 1'b1);

    // R3 address match accept, R8 single-strobe hold-off, R10 pulse width
    slave_addr = 3'd5; en_in = 3'd5; step(4);
    inta = 1; step(2);
    chk("R3", "ack not yet", ack_pulse, 1'b0);
    step(1);
    chk("R3", "ack pulse", ack_pulse, 1'b1);
    chk("R3", "int dropped", int_out, 1'b0);
    step(1);
    chk("R10", "ack one clock", ack_pulse, 1'b0);
    step(3);
    chk("R8", "no retrigger during strobe", int_out, 1'b0);
    inta = 0; step(3);
    chk("R8", "still held after fall", int_out, 1'b0);
    step(1);
    chk("R8", "int back 4 cycles after fall", int_out, 1'b1);

    // R4 mismatch
    en_in = 3'd3; step(4);
    inta = 1; step(3);
    chk("R4", "no ack on mismatch", ack_pulse, 1'b0);
    chk("R4", "int kept", int_out, 1'b1);
    step(2); inta = 0; step(4);
    chk("R4", "int kept after strobe", int_out, 1'b1);
    chk("R4", "no ack after strobe", ack_pulse, 1'b0);

    // R9 double-strobe chain sequence
    chain_mode = 1; two_ack = 1; en_in = 3'b010; req_pend = 4'b0001; step(4);
    chk("R6", "prio low while int", prio_out, 1'b0);
    inta = 1; step(3);
    chk("R7", "chain accept", ack_pulse, 1'b1);
    chk("R6", "prio back high", prio_out, 1'b1);
    step(1);
    inta = 0; step(6);
    chk("R9", "held between strobes", int_out, 1'b0);
    inta = 1; step(3);
    chk("R9", "no ack on second strobe", ack_pulse, 1'b0);
    step(1);
    inta = 0; step(3);
    chk("R9", "held until second fall", int_out, 1'b0);
    step(1);
    chk("R9", "int after second fall", int_out, 1'b1);

    // R5 abort by priority input
    two_ack = 0;
    en_in = 3'b000; step(1);
    chk("R5", "not before sync", int_out, 1'b1);
    step(1);
    chk("R5", "abort int", int_out, 1'b0);
    chk("R5", "abort prio", prio_out, 1'b0);
    step(5);
    chk("R5", "held low", int_out, 1'b0);
    en_in = 3'b010; step(3);
    chk("R5", "int resumes", int_out, 1'b1);
    chk("R6", "prio low again", prio_out, 1'b0);

    // R7 strobe with priority input low
    en_in = 3'b000; step(3);
    inta = 1; step(3);
    chk("R7", "no ack with prio low", ack_pulse, 1'b0);
    step(1); inta = 0; step(4);
    en_in = 3'b010; step(3);
    chk("R7", "int after blocked strobe", int_out, 1'b1);

    // R8 hold-off on a device not being served
    chain_mode = 0; slave_addr = 3'd1; en_in = 3'd0; req_pend = 0; step(4);
    inta = 1; step(3);
    req_pend = 4'b1000; step(4);
    chk("R8", "bystander held", int_out, 1'b0);
    inta = 0; step(3);
    chk("R8", "bystander held after fall", int_out, 1'b0);
    step(1);
    chk("R8", "bystander int", int_out, 1'b1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule